// File: doc/BRIEF.md
# Fault Collection and Reaction Unit

This block gathers failure notifications from a set of monitor inputs (96 by default) and records each one in a sticky status bit. Status bits are grouped into 32-bit words; fault number `n` lives in word `n / 32`, bit `n % 32`. For every fault a software-programmable routing decides whether it contributes to an interrupt request, to the active-low external error pin, or to a reset request. Each fault is also classed either as hardware-recoverable, where its status bit drops by itself once the monitor input falls, or as software-recoverable, where only an explicit software clear removes it.

Software reaches the unit through a plain synchronous register port: one write strobe, a 5-bit word address, 32-bit write data and a registered read data bus. Besides programming the routing, software can inject a fake fault by writing a fault number. This exercises the reaction path of monitors whose wiring allows it, and a build-time per-fault mask marks which ones do. Software clears latched faults by writing ones to a status word, and every bit it clears that way returns a one-cycle clear pulse to the monitor that raised it. The error pin can also be taken over by software and forced to either level.

Register map (word addresses): 0x00 control (bit 0 gives software ownership of the error pin, bit 1 drives it low while owned); 0x01 fake-fault number (write only, reads 0); 0x04+w status word w (write 1 to clear); 0x08+w recovery class (1 = hardware-recoverable); 0x0C+w interrupt routing; 0x10+w error-pin routing; 0x14+w reset routing.

Top module: `fault_collect_unit`

## Requirements
- R1: After reset every status word reads 0, `irq` and `rst_req` are 0, `err_n` is 1 and `mon_clr` is all zeros.
- R2: A fault input seen high at a clock edge sets status bit n (word n/32, bit n%32) at that edge, and a software-recoverable bit stays set after the input falls.
- R3: Writing number n to address 0x01 (bits 6:0) sets status bit n at that edge only if the fake-injection mask bit n is 1; a masked number, or a number of 96 or more, changes no status bit.
- R4: Writing a word to address 0x04+w clears the status bits written as 1 and leaves the bits written as 0 unchanged; a fault input that is high on the same edge keeps its bit set.
- R5: `mon_clr[n]` is high for exactly the one cycle after an edge where a status-clear write hit bit n while it was set, and stays low for clear writes to bits that were not set.
- R6: A fault whose recovery-class bit is 1 clears its status bit on the first edge where its input is low after having been high; a fake fault on such a fault stays latched until software clears it.
- R7: `irq` is the OR of status bits ANDed with the interrupt routing, valid in the same cycle the status changes.
- R8: `rst_req` follows the OR of status bits ANDed with the reset routing with exactly one cycle of added delay, both on assertion and on release.
- R9: While control bit 0 is 0, `err_n` is low exactly when a set status bit is routed to the pin; while control bit 0 is 1, `err_n` equals the inverse of control bit 1 regardless of faults.
- R10: Control, class and routing registers read back what was written, the fake-fault address reads 0, and read data appears one cycle after the address is presented.
- R11: A fake fault injected while the same real fault is already latched has no additional effect: a single clear write removes it and yields a single clear pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fault_in | input | NUM_FAULTS | Failure notifications from monitors, level sensitive |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for the previous cycle's address |
| irq | output | 1 | Interrupt request |
| err_n | output | 1 | External error pin, active low |
| rst_req | output | 1 | Reset request, registered |
| mon_clr | output | NUM_FAULTS | One-cycle clear pulses returned to monitors |

## Verification
Status bits, `irq` and `err_n` settle in the cycle of the edge that samples a fault input or a register write, so the bench looks at them at the following falling edge. `mon_clr` is registered and is therefore also visible at that falling edge, while `rst_req` carries one more register and is checked one full cycle later, including the cycle where it must still be high after a clear. Read data is checked at the falling edge after the edge that captured the address. Every fault number is swept through injection, real-input latching and clearing, and the expected bit position and mask outcome are computed from the number in the bench.

// File: rtl/fcu_pkg.sv
package fcu_pkg;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 5;
  localparam int MAX_WORDS = 4;

  typedef enum logic [2:0] {
    GRP_MISC  = 3'd0,
    GRP_STAT  = 3'd1,
    GRP_CLASS = 3'd2,
    GRP_IRQ   = 3'd3,
    GRP_ERR   = 3'd4,
    GRP_RST   = 3'd5
  } grp_e;

  localparam logic [1:0] MISC_CTRL = 2'd0;
  localparam logic [1:0] MISC_FAKE = 2'd1;

  function automatic int word_count(input int n);
    return (n + WORD_W - 1) / WORD_W;
  endfunction
endpackage

// File: rtl/fcu_cfg.sv
module fcu_cfg
  import fcu_pkg::*;
#(
  parameter int NUM_FAULTS = 96,
  parameter int NW = word_count(NUM_FAULTS),
  parameter int NFP = NW * WORD_W,
  parameter int IW = $clog2(NFP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [NFP-1:0]    status,
  output logic [NFP-1:0]    class_q,
  output logic [NFP-1:0]    irq_en,
  output logic [NFP-1:0]    err_en,
  output logic [NFP-1:0]    rst_en,
  output logic              sw_own,
  output logic              sw_low,
  output logic [NFP-1:0]    w1c_mask,
  output logic              fake_stb,
  output logic [IW-1:0]     fake_idx,
  output logic [WORD_W-1:0] rdata
);
  grp_e grp;
  logic [1:0] word;
  logic [NFP-1:0] valid;
  logic [WORD_W-1:0] rd_mux;

  assign grp  = grp_e'(addr[4:2]);
  assign word = addr[1:0];

  genvar b;
  generate
    for (b = 0; b < NFP; b++) begin : g_valid
      if (b < NUM_FAULTS) begin : g_on
        assign valid[b] = 1'b1;
      end else begin : g_off
        assign valid[b] = 1'b0;
      end
    end
  endgenerate

  assign fake_stb = wr_en && (grp == GRP_MISC) && (word == MISC_FAKE);
  assign fake_idx = wdata[IW-1:0];

  always_comb begin
    w1c_mask = '0;
    for (int w = 0; w < NW; w++) begin
      if (wr_en && grp == GRP_STAT && int'(word) == w)
        w1c_mask[w*WORD_W +: WORD_W] = wdata & valid[w*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      class_q <= '0;
      irq_en  <= '0;
      err_en  <= '0;
      rst_en  <= '0;
      sw_own  <= 1'b0;
      sw_low  <= 1'b0;
    end else if (wr_en) begin
      if (grp == GRP_MISC && word == MISC_CTRL) begin
        sw_own <= wdata[0];
        sw_low <= wdata[1];
      end
      for (int w = 0; w < NW; w++) begin
        if (int'(word) == w) begin
          case (grp)
            GRP_CLASS: class_q[w*WORD_W +: WORD_W] <= wdata & valid[w*WORD_W +: WORD_W];
            GRP_IRQ:   irq_en[w*WORD_W +: WORD_W]  <= wdata & valid[w*WORD_W +: WORD_W];
            GRP_ERR:   err_en[w*WORD_W +: WORD_W]  <= wdata & valid[w*WORD_W +: WORD_W];
            GRP_RST:   rst_en[w*WORD_W +: WORD_W]  <= wdata & valid[w*WORD_W +: WORD_W];
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (grp == GRP_MISC) begin
      if (word == MISC_CTRL) rd_mux = {{(WORD_W-2){1'b0}}, sw_low, sw_own};
    end else begin
      for (int w = 0; w < NW; w++) begin
        if (int'(word) == w) begin
          case (grp)
            GRP_STAT:  rd_mux = status[w*WORD_W +: WORD_W];
            GRP_CLASS: rd_mux = class_q[w*WORD_W +: WORD_W];
            GRP_IRQ:   rd_mux = irq_en[w*WORD_W +: WORD_W];
            GRP_ERR:   rd_mux = err_en[w*WORD_W +: WORD_W];
            GRP_RST:   rd_mux = rst_en[w*WORD_W +: WORD_W];
            default:   rd_mux = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd_mux;
  end

  // R3: the fake strobe never coincides with a status clear write
  p_fake_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fake_stb |-> (w1c_mask == '0));
endmodule

// File: rtl/fcu_status.sv
module fcu_status
  import fcu_pkg::*;
#(
  parameter int NUM_FAULTS = 96,
  parameter int NW = word_count(NUM_FAULTS),
  parameter int NFP = NW * WORD_W,
  parameter int IW = $clog2(NFP),
  parameter logic [NUM_FAULTS-1:0] FAKE_OK = '1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NFP-1:0] fin,
  input  logic [NFP-1:0] class_q,
  input  logic [NFP-1:0] w1c_mask,
  input  logic           fake_stb,
  input  logic [IW-1:0]  fake_idx,
  output logic [NFP-1:0] st_q,
  output logic [NFP-1:0] clr_q
);
  wire  [NFP-1:0] ok_pad;
  logic [NFP-1:0] fake_vec;
  logic [NFP-1:0] fin_q;
  logic [NFP-1:0] drop;
  logic [NFP-1:0] keep;

  genvar b;
  generate
    for (b = 0; b < NFP; b++) begin : g_ok
      if (b < NUM_FAULTS) begin : g_real
        assign ok_pad[b] = FAKE_OK[b];
      end else begin : g_pad
        assign ok_pad[b] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    fake_vec = '0;
    if (fake_stb && int'(fake_idx) < NUM_FAULTS) fake_vec[fake_idx] = 1'b1;
    fake_vec = fake_vec & ok_pad;
  end

  assign drop = class_q & fin_q & ~fin;
  assign keep = st_q & ~w1c_mask & ~drop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '0;
      fin_q <= '0;
      clr_q <= '0;
    end else begin
      st_q  <= keep | fin | fake_vec;
      fin_q <= fin;
      clr_q <= w1c_mask & st_q;
    end
  end

  // R2: every input seen high is latched at that edge
  p_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fin != '0) |=> ((st_q & $past(fin)) == $past(fin)));

  // R4: bits neither cleared nor recovered keep their value
  p_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (keep != '0) |=> ((st_q & $past(keep)) == $past(keep)));

  // R5: a clear pulse only goes to a monitor whose bit was set
  p_clr_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_q != '0) |-> ((clr_q & ~$past(st_q)) == '0));
endmodule

// File: rtl/fcu_react.sv
module fcu_react
  import fcu_pkg::*;
#(
  parameter int NW = 3,
  parameter int NFP = NW * WORD_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NFP-1:0] status,
  input  logic [NFP-1:0] irq_en,
  input  logic [NFP-1:0] err_en,
  input  logic [NFP-1:0] rst_en,
  input  logic           sw_own,
  input  logic           sw_low,
  output logic           irq,
  output logic           err_n,
  output logic           rst_req
);
  logic [NW-1:0] irq_w, err_w, rst_w;

  genvar w;
  generate
    for (w = 0; w < NW; w++) begin : g_word
      assign irq_w[w] = |(status[w*WORD_W +: WORD_W] & irq_en[w*WORD_W +: WORD_W]);
      assign err_w[w] = |(status[w*WORD_W +: WORD_W] & err_en[w*WORD_W +: WORD_W]);
      assign rst_w[w] = |(status[w*WORD_W +: WORD_W] & rst_en[w*WORD_W +: WORD_W]);
    end
  endgenerate

  assign irq   = |irq_w;
  assign err_n = sw_own ? ~sw_low : ~(|err_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_req <= 1'b0;
    else        rst_req <= |rst_w;
  end

  // R8: routed reset cause asserts the request one cycle later
  p_rst_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & rst_en) != '0) |=> rst_req);

  // R8: and releases it one cycle after the cause is gone
  p_rst_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & rst_en) == '0) |=> !rst_req);

  // R7: no interrupt without a routed latched fault
  p_irq_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((status & irq_en) != '0));

  // R9: routed fault pulls the pin low when hardware owns it
  p_err_hw_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_own && ((status & err_en) != '0)) |-> !err_n);
endmodule

// File: rtl/fault_collect_unit.sv
module fault_collect_unit
  import fcu_pkg::*;
#(
  parameter int NUM_FAULTS = 96,
  parameter logic [NUM_FAULTS-1:0] FAKE_OK = '1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_FAULTS-1:0] fault_in,
  input  logic                  reg_wr,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [WORD_W-1:0]     reg_wdata,
  output logic [WORD_W-1:0]     reg_rdata,
  output logic                  irq,
  output logic                  err_n,
  output logic                  rst_req,
  output logic [NUM_FAULTS-1:0] mon_clr
);
  localparam int NW  = word_count(NUM_FAULTS);
  localparam int NFP = NW * WORD_W;
  localparam int IW  = $clog2(NFP);

  logic [NFP-1:0] fin_pad, status, clr_pad;
  logic [NFP-1:0] class_q, irq_en, err_en, rst_en, w1c_mask;
  logic           sw_own, sw_low, fake_stb;
  logic [IW-1:0]  fake_idx;

  generate
    if (NFP > NUM_FAULTS) begin : g_pad
      assign fin_pad = {{(NFP-NUM_FAULTS){1'b0}}, fault_in};
    end else begin : g_nopad
      assign fin_pad = fault_in;
    end
  endgenerate

  fcu_cfg #(.NUM_FAULTS(NUM_FAULTS), .NW(NW), .NFP(NFP), .IW(IW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .status(status), .class_q(class_q), .irq_en(irq_en), .err_en(err_en),
    .rst_en(rst_en), .sw_own(sw_own), .sw_low(sw_low), .w1c_mask(w1c_mask),
    .fake_stb(fake_stb), .fake_idx(fake_idx), .rdata(reg_rdata)
  );

  fcu_status #(.NUM_FAULTS(NUM_FAULTS), .NW(NW), .NFP(NFP), .IW(IW),
               .FAKE_OK(FAKE_OK)) u_status (
    .clk(clk), .rst_n(rst_n), .fin(fin_pad), .class_q(class_q),
    .w1c_mask(w1c_mask), .fake_stb(fake_stb), .fake_idx(fake_idx),
    .st_q(status), .clr_q(clr_pad)
  );

  fcu_react #(.NW(NW), .NFP(NFP)) u_react (
    .clk(clk), .rst_n(rst_n), .status(status), .irq_en(irq_en),
    .err_en(err_en), .rst_en(rst_en), .sw_own(sw_own), .sw_low(sw_low),
    .irq(irq), .err_n(err_n), .rst_req(rst_req)
  );

  assign mon_clr = clr_pad[NUM_FAULTS-1:0];

  // R5: clear pulses last a single cycle when no new clear follows
  p_clr_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((mon_clr != '0) && !reg_wr) |=> (mon_clr == '0));
endmodule

// File: tb/tb_fault_collect_unit.sv
module tb_fault_collect_unit;
  localparam int NF = 96;

  function automatic logic [NF-1:0] mk_ok();
    logic [NF-1:0] v;
    for (int i = 0; i < NF; i++) v[i] = ((i % 7) != 3);
    return v;
  endfunction
  localparam logic [NF-1:0] OK = mk_ok();

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NF-1:0] fault_in = '0;
  logic reg_wr = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq, err_n, rst_req;
  logic [NF-1:0] mon_clr;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fault_collect_unit #(.NUM_FAULTS(NF), .FAKE_OK(OK)) dut (
    .clk(clk), .rst_n(rst_n), .fault_in(fault_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .err_n(err_n), .rst_req(rst_req), .mon_clr(mon_clr)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    @(posedge clk); @(negedge clk);
    d = reg_rdata;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int w = 0; w < 3; w++) begin
      rd(5'h04 + 5'(w), d); chk("R1 status", d, 0);
    end
    chk("R1 irq", irq, 0); chk("R1 err_n", err_n, 1);
    chk("R1 rst_req", rst_req, 0); chk("R1 mon_clr", mon_clr, 0);

    // R10 readback
    wr(5'h0C, 32'hA5A5_0F0F); wr(5'h0D, 32'h1234_5678); wr(5'h0E, 32'hFFFF_0001);
    wr(5'h08, 32'h0000_00C3); wr(5'h12, 32'h8000_0001); wr(5'h15, 32'h0F00_0000);
    wr(5'h00, 32'h2);
    rd(5'h0C, d); chk("R10 irq0", d, 32'hA5A5_0F0F);
    rd(5'h0D, d); chk("R10 irq1", d, 32'h1234_5678);
    rd(5'h0E, d); chk("R10 irq2", d, 32'hFFFF_0001);
    rd(5'h08, d); chk("R10 class0", d, 32'h0000_00C3);
    rd(5'h12, d); chk("R10 err2", d, 32'h8000_0001);
    rd(5'h15, d); chk("R10 rst1", d, 32'h0F00_0000);
    rd(5'h00, d); chk("R10 ctrl", d, 32'h2);
    rd(5'h01, d); chk("R10 fake reads 0", d, 0);
    wr(5'h08, 0); wr(5'h12, 0); wr(5'h15, 0); wr(5'h00, 0);
    for (int w = 0; w < 3; w++) wr(5'h0C + 5'(w), 32'hFFFF_FFFF);

    // R3 + R5 sweep over every fake number
    for (int i = 0; i < NF; i++) begin
      logic [31:0] bitv;
      bitv = 32'h1 << (i % 32);
      wr(5'h01, 32'(i));
      chk($sformatf("R3 irq idx %0d", i), irq, OK[i]);
      rd(5'h04 + 5'(i / 32), d);
      chk($sformatf("R3 status idx %0d", i), d, OK[i] ? bitv : 32'h0);
      wr(5'h04 + 5'(i / 32), bitv);
      chk($sformatf("R5 mon_clr idx %0d", i), mon_clr,
          OK[i] ? (128'h1 << i) : 128'h0);
      @(negedge clk);
      chk($sformatf("R5 pulse width idx %0d", i), mon_clr, 0);
    end
    wr(5'h01, 32'd0030 + 32'd18); // number 0x30
    rd(5'h05, d); chk("R3 index 0x30 -> word1 bit16", d, 32'h0001_0000);
    wr(5'h05, 32'h0001_0000);
    wr(5'h01, 32'd100);
    for (int w = 0; w < 3; w++) begin
      rd(5'h04 + 5'(w), d); chk("R3 out-of-range ignored", d, 0);
    end

    // R2 sweep over real inputs (software-recoverable)
    for (int i = 0; i < NF; i++) begin
      fault_in[i] = 1'b1;
      @(posedge clk); @(negedge clk);
      fault_in[i] = 1'b0;
      chk($sformatf("R2 irq in %0d", i), irq, 1);
      rd(5'h04 + 5'(i / 32), d);
      chk($sformatf("R2 sticky in %0d", i), d, 32'h1 << (i % 32));
      wr(5'h04 + 5'(i / 32), 32'h1 << (i % 32));
    end

    // R4 partial clear and set-wins
    fault_in[3:0] = 4'hF; @(posedge clk); @(negedge clk); fault_in[3:0] = 4'h0;
    wr(5'h04, 32'h5);
    rd(5'h04, d); chk("R4 partial clear", d, 32'hA);
    fault_in[1] = 1'b1;
    wr(5'h04, 32'h2);
    chk("R5 pulse on set-wins clear", mon_clr[1], 1);
    rd(5'h04, d); chk("R4 set wins", d, 32'hA);
    fault_in[1] = 1'b0;
    wr(5'h04, 32'hA);
    rd(5'h04, d); chk("R4 cleared", d, 0);
    wr(5'h04, 32'h4);
    chk("R5 no pulse for clear bit", mon_clr, 0);

    // R6 hardware-recoverable
    wr(5'h08, 32'h20);
    fault_in[5] = 1'b1; @(posedge clk); @(negedge clk);
    rd(5'h04, d); chk("R6 hw set", d, 32'h20);
    fault_in[5] = 1'b0; @(posedge clk); @(negedge clk);
    chk("R6 hw drop irq", irq, 0);
    rd(5'h04, d); chk("R6 hw recovered", d, 0);
    wr(5'h01, 32'd5);
    repeat (3) @(negedge clk);
    rd(5'h04, d); chk("R6 fake on hw stays", d, 32'h20);
    wr(5'h04, 32'h20); wr(5'h08, 0);

    // R7 routing of irq
    for (int w = 0; w < 3; w++) wr(5'h0C + 5'(w), 0);
    wr(5'h01, 32'd40);
    chk("R7 unrouted irq", irq, 0);
    wr(5'h0D, 32'h100);
    chk("R7 routed irq", irq, 1);
    wr(5'h05, 32'h100);
    chk("R7 irq after clear", irq, 0);

    // R8 reset request lag
    wr(5'h15, 32'h8);
    wr(5'h01, 32'd35);
    chk("R8 not yet", rst_req, 0);
    @(negedge clk); chk("R8 asserted", rst_req, 1);
    wr(5'h05, 32'h8);
    chk("R8 still high", rst_req, 1);
    @(negedge clk); chk("R8 released", rst_req, 0);
    wr(5'h15, 0);

    // R9 error pin
    wr(5'h10, 32'h4);
    wr(5'h01, 32'd2);
    chk("R9 hw low", err_n, 0);
    wr(5'h00, 32'h1); chk("R9 sw high", err_n, 1);
    wr(5'h04, 32'h4);
    wr(5'h00, 32'h3); chk("R9 sw low no fault", err_n, 0);
    wr(5'h00, 32'h0); chk("R9 hw idle", err_n, 1);

    // R11 fake on already latched fault
    fault_in[11] = 1'b1; @(posedge clk); @(negedge clk); fault_in[11] = 1'b0;
    wr(5'h01, 32'd11);
    rd(5'h04, d); chk("R11 single bit", d, 32'h800);
    wr(5'h04, 32'h800);
    chk("R11 one pulse", mon_clr, 128'h800);
    rd(5'h04, d); chk("R11 one clear", d, 0);
    chk("R11 no further pulse", mon_clr, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule